// File: doc/BRIEF.md
# Flash command interface controller

This block is the command-decoding front end of a byte-wide flash memory made of sixteen 64 KB blocks on a 20-bit address. The bus strobes are active low and are sampled on the block clock. A write cycle runs while chip enable and write enable are both low. The block captures the address and data of each write cycle and interprets the data byte as a command. From those commands it keeps a read mode (array, identifier codes or status), a lock bit for each block, a master lock bit and a status byte with sticky error flags.

Erase, byte-write and lock commands take two bus cycles. They are accepted only when the programming supply is reported at its high level and the lock rules allow them. An accepted operation is modelled by a busy counter that holds the ready flag low for a fixed number of clocks. The storage array itself is a stub that always reads FFh.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write cycle exists only while `ce_n` and `we_n` are both low. Driving only one of them low has no effect on mode, locks or status.
- R2: A command is taken from the `din` and `addr` values present in the last clock cycle in which both strobes were low, and it is acted on when the first of `we_n` or `ce_n` rises. Changes to `din` after that first rise are ignored.
- R3: First-cycle command FFh selects array reads, 90h selects identifier reads and 70h selects status reads. Array reads return FFh. `dout` is 00h whenever `oe_n` or `ce_n` is high.
- R4: In identifier mode, address 00000h returns MFR_CODE, 00001h returns DEV_CODE and 00003h returns the master lock bit in bit 0. Address offset 0002h inside block b (addr[19:16]=b) returns block b's lock bit in bit 0. Every other address returns 00h.
- R5: The status byte is {ready, 0, erase_err, write_err, vpp_err, 3'b000}, with ready in bit 7, erase_err in bit 5, write_err in bit 4 and vpp_err in bit 3. Error bits stay set until first-cycle command 50h clears all three.
- R6: Block erase is 20h then D0h. Byte write is 40h then any data byte. Both target block addr[19:16] of the second cycle. If that block is locked, erase sets erase_err and write sets write_err, and no busy period starts.
- R7: Set block lock is 60h then 01h, on block addr[19:16]. Set master lock is 60h then F1h. Clear all block locks is 60h then D0h. The master and clear commands accept any address. While the master lock is set, set block lock fails with write_err and clear fails with erase_err, and no lock changes. Only reset clears the master lock.
- R8: With `vpp_high` low, every second cycle of erase, write or lock sets vpp_err plus its own error bit (erase_err for erase and clear; write_err for write, set block lock and set master lock). It changes no lock bit.
- R9: A second cycle other than the codes listed in R6 and R7 sets both erase_err and write_err and returns to first-cycle decoding.
- R10: A first-cycle 20h, 40h or 60h switches to status reads. An accepted operation holds ready low for exactly BUSY_CYCLES clocks after the edge that accepts it. Write cycles ending while ready is low are ignored.
- R11: A first-cycle byte that is not one of FFh, 90h, 70h, 50h, 20h, 40h or 60h is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 20 | Byte address |
| din | input | 8 | Command or data byte |
| vpp_high | input | 1 | High when the programming supply is at its high level |
| dout | output | 8 | Read data |

## Verification
A wrong lock bit shows up as a wrong bit 0 of the identifier read at offset 0002h of that block. It also shows as an erase or write on that block that errors when it should run, or runs when it should error. Both can be seen on the first read after the command. A stuck phase or mode shows on the next read as the wrong kind of data: FFh, an identifier code or a status byte. A miscounted busy period shows as bit 7 of the status read rising one clock early or late. A wrong lock-change rule is caught by the checker on the clock edge where a lock bit changes while the supply is low or the counter is running.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W = 20,
  parameter int BLK_BITS = 4,
  parameter int BUSY_CYCLES = 8,
  parameter logic [7:0] MFR_CODE = 8'h5A,
  parameter logic [7:0] DEV_CODE = 8'hA6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              vpp_high,
  output logic [7:0]        dout
);
  localparam int NBLK = 1 << BLK_BITS;
  localparam int OFS_W = ADDR_W - BLK_BITS;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] BUSY_LD = CNT_W'(BUSY_CYCLES);

  typedef enum logic [1:0] {M_ARRAY, M_ID, M_STAT} mode_t;
  typedef enum logic [1:0] {P_IDLE, P_ERASE, P_WRITE, P_LOCK} phase_t;

  mode_t mode_q;
  phase_t phase_q;
  logic act_q;
  logic [BLK_BITS-1:0] blk_s;
  logic [7:0] d_s;
  logic [NBLK-1:0] lock_q;
  logic master_q;
  logic ers_q, wr_q, vpe_q;
  logic [CNT_W-1:0] cnt_q;

  wire act = !we_n && !ce_n;
  wire ready = (cnt_q == '0);
  wire take = act_q && !act && ready;
  wire blk_locked = lock_q[blk_s];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      blk_s <= '0;
      d_s <= '0;
      mode_q <= M_ARRAY;
      phase_q <= P_IDLE;
      lock_q <= '0;
      master_q <= 1'b0;
      ers_q <= 1'b0;
      wr_q <= 1'b0;
      vpe_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act;
      if (act) begin
        blk_s <= addr[ADDR_W-1 -: BLK_BITS];
        d_s <= din;
      end
      if (!ready) cnt_q <= cnt_q - 1'b1;
      if (take) begin
        case (phase_q)
          P_IDLE: begin
            case (d_s)
              8'hFF: mode_q <= M_ARRAY;
              8'h90: mode_q <= M_ID;
              8'h70: mode_q <= M_STAT;
              8'h50: begin
                ers_q <= 1'b0;
                wr_q <= 1'b0;
                vpe_q <= 1'b0;
              end
              8'h20: begin
                phase_q <= P_ERASE;
                mode_q <= M_STAT;
              end
              8'h40: begin
                phase_q <= P_WRITE;
                mode_q <= M_STAT;
              end
              8'h60: begin
                phase_q <= P_LOCK;
                mode_q <= M_STAT;
              end
              default: ;
            endcase
          end
          P_ERASE: begin
            phase_q <= P_IDLE;
            if (d_s != 8'hD0) begin
              ers_q <= 1'b1;
              wr_q <= 1'b1;
            end else if (!vpp_high) begin
              vpe_q <= 1'b1;
              ers_q <= 1'b1;
            end else if (blk_locked) ers_q <= 1'b1;
            else cnt_q <= BUSY_LD;
          end
          P_WRITE: begin
            phase_q <= P_IDLE;
            if (!vpp_high) begin
              vpe_q <= 1'b1;
              wr_q <= 1'b1;
            end else if (blk_locked) wr_q <= 1'b1;
            else cnt_q <= BUSY_LD;
          end
          default: begin
            phase_q <= P_IDLE;
            case (d_s)
              8'h01: begin
                if (!vpp_high) begin
                  vpe_q <= 1'b1;
                  wr_q <= 1'b1;
                end else if (master_q) wr_q <= 1'b1;
                else begin
                  lock_q[blk_s] <= 1'b1;
                  cnt_q <= BUSY_LD;
                end
              end
              8'hF1: begin
                if (!vpp_high) begin
                  vpe_q <= 1'b1;
                  wr_q <= 1'b1;
                end else begin
                  master_q <= 1'b1;
                  cnt_q <= BUSY_LD;
                end
              end
              8'hD0: begin
                if (!vpp_high) begin
                  vpe_q <= 1'b1;
                  ers_q <= 1'b1;
                end else if (master_q) ers_q <= 1'b1;
                else begin
                  lock_q <= '0;
                  cnt_q <= BUSY_LD;
                end
              end
              default: begin
                ers_q <= 1'b1;
                wr_q <= 1'b1;
              end
            endcase
          end
        endcase
      end
    end
  end

  wire [BLK_BITS-1:0] rd_blk = addr[ADDR_W-1 -: BLK_BITS];
  wire [OFS_W-1:0] rd_ofs = addr[OFS_W-1:0];
  logic [7:0] id_val, rd_val;

  always_comb begin
    id_val = 8'h00;
    if (rd_ofs == OFS_W'(2)) id_val = {7'b0, lock_q[rd_blk]};
    else if (rd_blk == '0) begin
      case (rd_ofs)
        OFS_W'(0): id_val = MFR_CODE;
        OFS_W'(1): id_val = DEV_CODE;
        OFS_W'(3): id_val = {7'b0, master_q};
        default:   id_val = 8'h00;
      endcase
    end
  end

  always_comb begin
    case (mode_q)
      M_ID:    rd_val = id_val;
      M_STAT:  rd_val = {ready, 1'b0, ers_q, wr_q, vpe_q, 3'b000};
      default: rd_val = 8'hFF;
    endcase
  end

  assign dout = (!oe_n && !ce_n) ? rd_val : 8'h00;
endmodule

module flash_cmd_ctrl_chk #(
  parameter int NBLK = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            oe_n,
  input logic            ce_n,
  input logic            vpp_high,
  input logic [7:0]      dout,
  input logic [NBLK-1:0] lock,
  input logic            master,
  input logic            ready
);
  AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || ce_n) |-> dout == 8'h00); // R3
  AST_VPP_LOW_LOCKS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_high |=> ($stable(lock) && $stable(master))); // R8
  AST_MASTER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    master |=> master); // R7
  AST_BUSY_IGNORES_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ($stable(lock) && $stable(master))); // R10
  AST_LOCK_CHANGE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock) |-> !ready); // R10
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .ce_n(ce_n), .vpp_high(vpp_high),
  .dout(dout), .lock(lock_q), .master(master_q), .ready(ready)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int BUSY = 12;
  localparam logic [7:0] MFR = 8'h5A;
  localparam logic [7:0] DEV = 8'hA6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vpp_high = 1'b1;
  logic [19:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;

  int checks = 0, failures = 0;
  logic [15:0] e_lock = '0;
  logic e_master = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_ctrl #(.BUSY_CYCLES(BUSY), .MFR_CODE(MFR), .DEV_CODE(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .vpp_high(vpp_high), .dout(dout));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [19:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; oe_n = 1'b0; ce_n = 1'b0;
    #1 v = dout;
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic busy_len(output int n, output logic [7:0] first);
    n = 0;
    oe_n = 1'b0; ce_n = 1'b0;
    #1 first = dout;
    while (dout[7] == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk); #1;
    end
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  function automatic logic [7:0] sr(input bit e, input bit w, input bit v);
    return {1'b1, 1'b0, e, w, v, 3'b000};
  endfunction

  function automatic logic [7:0] id_exp(input logic [19:0] a);
    if (a[15:0] == 16'd2) return {7'b0, e_lock[a[19:16]]};
    if (a[19:16] != 4'd0) return 8'h00;
    case (a[15:0])
      16'd0: return MFR;
      16'd1: return DEV;
      16'd3: return {7'b0, e_master};
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v, f;
    int n;
    logic [15:0] ofs [6] = '{16'h0, 16'h1, 16'h2, 16'h3, 16'h4, 16'hFFFF};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(20'h00000, v); chk("R3 reset array read", v, 8'hFF);
    rd(20'h00000, v); oe_n = 1'b0; ce_n = 1'b1; #1 chk("R3 ce_n high gives zero", dout, 0); oe_n = 1'b1;
    wr(0, 8'h70); rd(0, v); chk("R5 status after reset", v, sr(0,0,0));

    @(negedge clk); din = 8'h90; we_n = 1'b0; ce_n = 1'b1;
    repeat (3) @(negedge clk); we_n = 1'b1; @(negedge clk);
    @(negedge clk); din = 8'hFF; ce_n = 1'b0; we_n = 1'b1;
    repeat (3) @(negedge clk); ce_n = 1'b1; @(negedge clk);
    rd(0, v); chk("R1 single strobe ignored", v, sr(0,0,0));

    @(negedge clk); din = 8'h70; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); din = 8'h90;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; @(negedge clk);
    rd(0, v); chk("R2 last active data used", v, MFR);
    @(negedge clk); din = 8'hFF; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk); we_n = 1'b1; din = 8'h70;
    @(negedge clk); ce_n = 1'b1; @(negedge clk);
    rd(0, v); chk("R2 we_n rises first", v, 8'hFF);
    @(negedge clk); din = 8'h90; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk); ce_n = 1'b1; din = 8'h70;
    @(negedge clk); we_n = 1'b1; @(negedge clk);
    rd(20'h00001, v); chk("R2 ce_n rises first", v, DEV);

    for (int b = 0; b < 16; b += 3) begin
      wr({b[3:0], 16'h1234}, 8'h60); wr({b[3:0], 16'h1234}, 8'h01);
      e_lock[b] = 1'b1;
      busy_len(n, f);
      chk("R10 busy length set block lock", n, BUSY);
      if (b == 0) chk("R5 status while busy", f, 8'h00);
    end
    wr(0, 8'h90);
    for (int b = 0; b < 16; b++)
      for (int k = 0; k < 6; k++) begin
        rd({b[3:0], ofs[k]}, v);
        chk("R4 identifier sweep", v, id_exp({b[3:0], ofs[k]}));
      end

    for (int b = 0; b < 16; b++) begin
      wr({b[3:0], 16'h0}, 8'h20); wr({b[3:0], 16'hABCD}, 8'hD0);
      if (e_lock[b]) begin
        rd(0, v); chk("R6 erase locked block", v, sr(1,0,0));
        wr(0, 8'h50); rd(0, v); chk("R5 clear status", v, sr(0,0,0));
      end else begin
        busy_len(n, f); chk("R6 erase runs", n, BUSY);
      end
      wr({b[3:0], 16'h0}, 8'h40); wr({b[3:0], 16'h0042}, 8'h5C);
      if (e_lock[b]) begin
        rd(0, v); chk("R6 write locked block", v, sr(0,1,0));
        wr(0, 8'h50);
      end else begin
        busy_len(n, f); chk("R6 write runs", n, BUSY);
      end
    end

    wr(20'h10000, 8'h20); wr(20'h10000, 8'hD0);
    wr(0, 8'h90);
    busy_len(n, f);
    rd(0, v); chk("R10 command during busy ignored", v, sr(0,0,0));

    vpp_high = 1'b0;
    wr(20'h10000, 8'h20); wr(20'h10000, 8'hD0);
    rd(0, v); chk("R8 erase low vpp", v, sr(1,0,1)); wr(0, 8'h50);
    wr(20'h10000, 8'h40); wr(20'h10000, 8'h11);
    rd(0, v); chk("R8 write low vpp", v, sr(0,1,1)); wr(0, 8'h50);
    wr(20'h10000, 8'h60); wr(20'h10000, 8'h01);
    rd(0, v); chk("R8 set lock low vpp", v, sr(0,1,1)); wr(0, 8'h50);
    wr(20'h00000, 8'h60); wr(20'h00000, 8'hD0);
    rd(0, v); chk("R8 clear locks low vpp", v, sr(1,0,1)); wr(0, 8'h50);
    wr(0, 8'h60); wr(0, 8'hF1);
    rd(0, v); chk("R8 master low vpp", v, sr(0,1,1)); wr(0, 8'h50);
    wr(0, 8'h90);
    rd(20'h10002, v); chk("R8 block 1 lock unchanged", v, 0);
    rd(20'h00002, v); chk("R8 block 0 lock unchanged", v, 1);
    rd(20'h00003, v); chk("R8 master unchanged", v, 0);
    vpp_high = 1'b1;

    wr(0, 8'h20); wr(0, 8'h33);
    rd(0, v); chk("R9 bad erase confirm", v, sr(1,1,0));
    wr(0, 8'hD0);
    rd(0, v); chk("R9 back to idle decoding", v, sr(1,1,0));
    wr(0, 8'h50);
    wr(0, 8'h60); wr(0, 8'h77);
    rd(0, v); chk("R9 bad lock confirm", v, sr(1,1,0));
    wr(0, 8'h50);
    wr(0, 8'h12);
    rd(0, v); chk("R11 unknown first cycle", v, sr(0,0,0));
    wr(0, 8'h90); wr(0, 8'hC3);
    rd(0, v); chk("R11 unknown keeps identifier mode", v, MFR);

    wr(20'h5555A, 8'h60); wr(20'h5555A, 8'hD0);
    e_lock = '0;
    busy_len(n, f); chk("R7 clear locks runs", n, BUSY);
    wr(20'h20000, 8'h60); wr(20'h20000, 8'h01); e_lock[2] = 1'b1; busy_len(n, f);
    wr(20'hABCDE, 8'h60); wr(20'hABCDE, 8'hF1); e_master = 1'b1;
    busy_len(n, f); chk("R7 set master runs", n, BUSY);
    wr(20'h50000, 8'h60); wr(20'h50000, 8'h01);
    rd(0, v); chk("R7 set lock under master", v, sr(0,1,0)); wr(0, 8'h50);
    wr(0, 8'h60); wr(0, 8'hD0);
    rd(0, v); chk("R7 clear under master", v, sr(1,0,0)); wr(0, 8'h50);
    wr(0, 8'h90);
    for (int b = 0; b < 16; b++) begin
      rd({b[3:0], 16'h2}, v); chk("R7 locks under master", v, id_exp({b[3:0], 16'h2}));
    end
    rd(20'h00003, v); chk("R4 master code", v, 1);
    wr(20'h30000, 8'h20); wr(20'h30000, 8'hD0);
    busy_len(n, f); chk("R6 unlocked erase under master", n, BUSY);
    wr(0, 8'hFF);
    rd(20'h3ABCD, v); chk("R3 array mode", v, 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule